// File: doc/BRIEF.md
# Reloadable System Tick Timer

A periodic down-counter for a processor subsystem. Software programs a reload value, picks whether the counter advances on every core clock or only on cycles where an external reference tick enable is high, and turns the timer on. The counter then counts from the reload value down to zero and wraps back to the reload value. Each wrap sets a sticky wrap flag and, when interrupts are enabled, emits a one-cycle request pulse. A separate pending-state block consumes that pulse.

Four 32-bit word registers sit on a simple single-cycle register bus: control/status, reload, current value and a read-only calibration constant. Read data is combinational and is valid while the read strobe is high. Read and write side effects take place on the clock edge that ends the access. A synchronous, active-high reset clears every register.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value registers all read 0 and `irq` is low.
- R2: Control/status is at `addr`=0. Bit 0 is enable, bit 1 is interrupt enable, bit 2 is source select (1 = every clock, 0 = reference tick) and bit 16 is the wrap flag. Only bits 2:0 take write data. Every other bit reads 0.
- R3: A read of control/status returns the flag, then clears it on that clock edge. If a wrap occurs on the same edge, the flag stays set.
- R4: Reload is at `addr`=1. Only bits 23:0 are stored, and bits 31:24 read 0.
- R5: A control write that turns enable from 0 to 1 loads the counter with the reload value. The counter then decrements once per counting tick. A counting tick at zero reloads it, so one period is reload+1 ticks.
- R6: With source select 0 the counter moves only on cycles where `ref_tick` is 1. With source select 1 it moves on every clock.
- R7: A wrap sets the flag. If interrupt enable is set, a wrap also raises `irq` for exactly one cycle, starting on the edge of the wrap.
- R8: If the reload value is 0 when a wrap occurs, enable clears itself and no further wraps or pulses occur.
- R9: Any write to current value (`addr`=2) reloads the counter and clears the flag. The data is ignored. No wrap occurs in that cycle.
- R10: Current value reads 0 while disabled. While enabled it reads the counter, which is 0 during the last tick before the wrap.
- R11: A control write that keeps enable set but changes source select reloads the counter.
- R12: Calibration (`addr`=3) always reads 10000. Writes to it have no effect.
- R13: `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick enable, used when source select is 0 |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Word address: 0 control/status, 1 reload, 2 current, 3 calibration |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rd_en` is high |
| irq | output | 1 | One-cycle interrupt request per wrap |

## Verification
A wrong counter value shows up on the first current-value read. It also shifts the next `irq` pulse by the size of the error, so the wrap spacing exposes it within one period. A wrong flag or enable bit shows up on the next control/status read. Missing or doubled pulses show up within one cycle. The bench compares `rdata` and `irq` with a behavioural model on every clock, so the first divergence is reported in the cycle where it appears.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int          CNT_W = 24,
  parameter logic [31:0] CALIB = 32'd10000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ref_tick,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RELD = 2'd1;
  localparam logic [1:0] A_CURR = 2'd2;
  localparam logic [1:0] A_CALB = 2'd3;
  localparam int         FLAG_BIT = 16;

  logic             en_q, ie_q, cs_q, flag_q, irq_q;
  logic [CNT_W-1:0] reload_q, cnt_q;

  logic ctrl_wr, reld_wr, curr_wr, ctrl_rd;
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign reld_wr = wr_en && (addr == A_RELD);
  assign curr_wr = wr_en && (addr == A_CURR);
  assign ctrl_rd = rd_en && (addr == A_CTRL);

  logic en_n, ie_n, cs_n;
  assign en_n = ctrl_wr ? wdata[0] : en_q;
  assign ie_n = ctrl_wr ? wdata[1] : ie_q;
  assign cs_n = ctrl_wr ? wdata[2] : cs_q;

  logic load, step, wrap;
  assign load = curr_wr || (ctrl_wr && wdata[0] && (!en_q || (wdata[2] != cs_q)));
  assign step = en_n && !load && (cs_q || ref_tick);
  assign wrap = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      cs_q     <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      en_q  <= (wrap && (reload_q == '0)) ? 1'b0 : en_n;
      ie_q  <= ie_n;
      cs_q  <= cs_n;
      irq_q <= wrap && ie_n;
      if (reld_wr)
        reload_q <= wdata[CNT_W-1:0];
      if (load || wrap)
        cnt_q <= reload_q;
      else if (step)
        cnt_q <= cnt_q - 1'b1;
      if (wrap)
        flag_q <= 1'b1;
      else if (ctrl_rd || curr_wr)
        flag_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_CTRL: begin
          rdata[FLAG_BIT] = flag_q;
          rdata[2:0]      = {cs_q, ie_q, en_q};
        end
        A_RELD: rdata = 32'(reload_q);
        A_CURR: rdata = en_q ? 32'(cnt_q) : '0;
        A_CALB: rdata = CALIB;
        default: rdata = '0;
      endcase
    end
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int          CNT_W = 24,
  parameter logic [31:0] CALIB = 32'd10000
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_tick,
  input logic             rd_en,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [31:0]      rdata,
  input logic             irq,
  input logic             en_q,
  input logic             cs_q,
  input logic             flag_q,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) irq |=> !irq); // R7
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst) irq |-> flag_q); // R7
  AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd0 && !wrap) |=> !flag_q); // R3
  AST_ZERO_RELOAD_STOP: assert property (@(posedge clk) disable iff (rst)
    (wrap && reload_q == '0) |=> !en_q); // R8
  AST_CURR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd2) |=> (!flag_q && cnt_q == $past(reload_q))); // R9
  AST_IDLE_CURR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd2 && !en_q) |-> rdata == 32'd0); // R10
  AST_CALIB_CONST: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd3) |-> rdata == CALIB); // R12
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rdata == 32'd0); // R13
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_q && !cs_q && !ref_tick && !wr_en) |=> $stable(cnt_q)); // R6

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .CALIB(CALIB)) u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .rdata(rdata), .irq(irq), .en_q(en_q), .cs_q(cs_q),
  .flag_q(flag_q), .wrap(wrap), .cnt_q(cnt_q), .reload_q(reload_q)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  always #5 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_en, m_ie, m_cs, m_flag, m_irq;
  int m_rel, m_cnt;
  bit seen_irq;
  logic [31:0] got;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read();
    logic [31:0] v = '0;
    if (rd_en) begin
      case (addr)
        2'd0: v = (32'(m_flag) << 16) | (32'(m_cs) << 2) | (32'(m_ie) << 1) | 32'(m_en);
        2'd1: v = 32'(m_rel);
        2'd2: v = m_en ? 32'(m_cnt) : 32'd0;
        default: v = 32'd10000;
      endcase
    end
    return v;
  endfunction

  task automatic model_step();
    bit cw, curw, rw, crd, en_n, ie_n, cs_n, ld, adv, wr;
    if (rst) begin
      m_en = 0; m_ie = 0; m_cs = 0; m_flag = 0; m_irq = 0; m_rel = 0; m_cnt = 0;
    end else begin
      cw   = wr_en && addr == 2'd0;
      rw   = wr_en && addr == 2'd1;
      curw = wr_en && addr == 2'd2;
      crd  = rd_en && addr == 2'd0;
      en_n = cw ? wdata[0] : m_en;
      ie_n = cw ? wdata[1] : m_ie;
      cs_n = cw ? wdata[2] : m_cs;
      ld   = curw || (cw && wdata[0] && (!m_en || wdata[2] != m_cs));
      adv  = en_n && !ld && (m_cs || ref_tick);
      wr   = adv && m_cnt == 0;
      m_irq = wr && ie_n;
      if (ld || wr) m_cnt = m_rel;
      else if (adv) m_cnt = m_cnt - 1;
      if (wr) m_flag = 1;
      else if (crd || curw) m_flag = 0;
      m_en = (wr && m_rel == 0) ? 1'b0 : en_n;
      m_ie = ie_n;
      m_cs = cs_n;
      if (rw) m_rel = int'(wdata[23:0]);
    end
  endtask

  // one clock: compare outputs, take the edge, advance the model
  task automatic go();
    #1;
    if (!rst) begin
      chk(rd_en ? (addr == 2'd0 ? "R3 ctrl read" : addr == 2'd1 ? "R4 reload read" :
                   addr == 2'd2 ? "R5 current read" : "R12 calib read")
                : "R13 idle rdata", rdata, model_read());
      chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
    end
    seen_irq = irq;
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    go();
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1; wr_en = 0; addr = a;
    #1 got = rdata;
    go();
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) go();
  endtask

  initial begin
    int first, second, n, cnt_irq;
    @(negedge clk);
    idle(3);
    rst = 0;

    // R1 reset state
    rd(2'd0); chk("R1 ctrl after reset", got, 32'd0);
    rd(2'd1); chk("R1 reload after reset", got, 32'd0);
    rd(2'd2); chk("R1 current after reset", got, 32'd0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);

    // R4 only 24 bits kept
    wr(2'd1, 32'hFFAB_CDEF);
    rd(2'd1); chk("R4 reload width", got, 32'h00AB_CDEF);

    // R2 non-writable bits
    wr(2'd0, 32'hFFFF_FFF8);
    rd(2'd0); chk("R2 upper ctrl bits", got, 32'd0);

    // R5 start and period
    wr(2'd1, 32'd4);
    wr(2'd0, 32'd7);
    rd(2'd2); chk("R5 load on enable", got, 32'd4);
    first = -1; second = -1;
    for (int i = 0; i < 30; i++) begin
      go();
      if (seen_irq) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
    chk("R5 period reload+1", 32'(second - first), 32'd5);

    // R3 read clears flag
    n = 0;
    while (!seen_irq && n < 20) begin go(); n++; end
    rd(2'd0); chk("R3 flag visible", got, 32'h0001_0007);
    rd(2'd0); chk("R3 flag cleared", got, 32'h0000_0007);

    // R9 write to current
    idle(3);
    wr(2'd2, 32'h0000_0123);
    rd(2'd2); chk("R9 current write reloads", got, 32'd4);
    rd(2'd0); chk("R9 current write clears flag", got, 32'h0000_0007);

    // R11 + R6 source select
    wr(2'd0, 32'd3);
    rd(2'd2); chk("R11 reload on source change", got, 32'd4);
    idle(6);
    rd(2'd2); chk("R6 no count without ref tick", got, 32'd4);
    ref_tick = 1; go(); ref_tick = 0;
    rd(2'd2); chk("R6 count on ref tick", got, 32'd3);
    wr(2'd0, 32'd7);
    rd(2'd2); chk("R11 reload on source change back", got, 32'd4);

    // R8 zero reload stops timer
    wr(2'd1, 32'd0);
    idle(10);
    rd(2'd0); chk("R8 enable self-clears", got, 32'h0001_0006);
    rd(2'd2); chk("R10 current zero when disabled", got, 32'd0);
    cnt_irq = 0;
    for (int i = 0; i < 10; i++) begin go(); if (seen_irq) cnt_irq++; end
    chk("R8 no pulses after stop", 32'(cnt_irq), 32'd0);

    // R10 zero tick before wrap
    wr(2'd1, 32'd2);
    wr(2'd0, 32'd7);
    rd(2'd2); chk("R10 seq 2", got, 32'd2);
    rd(2'd2); chk("R10 seq 1", got, 32'd1);
    rd(2'd2); chk("R10 zero before wrap", got, 32'd0);
    rd(2'd2); chk("R5 wrap reloads", got, 32'd2);
    for (int i = 0; i < 6; i++) rd(2'd0);

    // R12 calibration constant
    rd(2'd3); chk("R12 calib", got, 32'd10000);
    wr(2'd3, 32'd0);
    rd(2'd3); chk("R12 calib after write", got, 32'd10000);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      rd_en    = 1'($urandom % 2);
      wr_en    = ($urandom % 5) == 0;
      addr     = 2'($urandom % 4);
      wdata    = $urandom & 32'hFF00_0007;
      ref_tick = 1'($urandom % 2);
      go();
    end
    rd_en = 0; wr_en = 0;
    idle(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule